// File: doc/BRIEF.md
# Open-Row DRAM Line-Fill Sequencer

This block sits between a cache miss handler and a simplified DRAM command port. It takes one cache-line fill request at a time, as a word address with a valid/ready handshake. It then issues the row and column commands the memory needs, waiting a programmable number of memory cycles after each one. For every bank it remembers which row is held in the sense latches. A request that lands on that row goes straight to the column read. A request to any other row first closes the bank and then opens the new row.

The line comes back as pairs of 64-bit words, two per memory cycle, in the way a double-data-rate bus delivers them. The word the requester named comes first. The other words of the line follow in ascending order and wrap around the end of the line. Each word carries its index within the line, so the cache can store it directly and can use the critical word as soon as the first pair arrives. The line size (32 or 64 bytes), the bank count, the address split and the three waits are set at elaboration.

Top module: `dram_line_filler`

## Requirements
- R1: After reset, `req_ready_o` is 1, `cmd_o` is 0 (no operation) and `fill_valid_o` is 0.
- R2: A request that misses the open row of its bank puts command 1 (precharge) on `cmd_o` in the cycle after acceptance. Command 2 (activate), carrying the request's bank and row, follows T_RP cycles after the precharge. Command 3 (read) follows T_RCD cycles after the activate. Each command lasts one cycle and nothing is issued in between.
- R3: The first word pair appears on the fill outputs T_CL+1 cycles after the read command. The DRAM data pins are sampled in the T_CL-th cycle after the read and in each following cycle of the burst.
- R4: A request whose bank holds the requested row issues no precharge or activate. Its read command appears in the cycle after acceptance.
- R5: Each bank tracks its open row separately, and activity in one bank leaves another bank's open row untouched. Reset closes every bank, so the first request to any bank takes the full precharge, activate and read path.
- R6: The read command carries the full requested column. The word-in-line offset c is the low log2(words per line) bits of the address. Pair j has index (c+2j) mod W in slot 0 and (c+2j+1) mod W in slot 1, where W is the number of words per line. Each slot carries the word read for that index.
- R7: `fill_valid_o` is high for exactly W/2 consecutive cycles per line, and `fill_last_o` is high only with the final pair.
- R8: `req_ready_o` is low from the cycle after acceptance until the last pair is presented. It is high again in that same cycle, so a new request can be accepted while the last pair is on the outputs.
- R9: A request held while `req_ready_o` is low is not taken and does not alter the line in progress. It is accepted at the first clock edge where ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Fill request present |
| req_ready_o | output | 1 | Sequencer idle, request taken at this edge |
| req_addr_i | input | ADDR_W | Word address {row, bank, column} |
| cmd_o | output | 2 | 0 none, 1 precharge, 2 activate, 3 read |
| cmd_bank_o | output | BANK_W | Bank of the current command |
| cmd_row_o | output | ROW_W | Row for activate |
| cmd_col_o | output | COL_W | Critical column for read |
| dq0_i | input | WORD_W | First word of the pair on the DRAM data pins |
| dq1_i | input | WORD_W | Second word of the pair on the DRAM data pins |
| fill_valid_o | output | 1 | Word pair valid |
| fill_last_o | output | 1 | Final pair of the line |
| fill_idx0_o | output | OFF_W | Line index of slot 0 |
| fill_idx1_o | output | OFF_W | Line index of slot 1 |
| fill_data0_o | output | WORD_W | Slot 0 word |
| fill_data1_o | output | WORD_W | Slot 1 word |

## Verification
The delivery of the final word pair and the acceptance of the next fill request can fall in the same cycle. That is the only point where the handshake and the burst engine touch. The bench provokes it by holding a second request valid through an entire line, with a different address, and expects it to be taken at the edge right after the last pair is presented. It judges the overlap by requiring that the first line shows no extra commands and is delivered intact, and that the second line's precharge appears exactly one cycle after the last pair of the first.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_PRE = 2'd1,
      CMD_ACT = 2'd2,
      CMD_RD  = 2'd3
   } dram_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WRP,
      ST_ACT,
      ST_WRCD,
      ST_RD,
      ST_WCL,
      ST_BURST
   } seq_state_e;
endpackage

// File: rtl/lf_wait_timer.sv
module lf_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             expire_o,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire_o = (cnt_q == CNT_W'(1));
   assign busy_o   = (cnt_q != '0);
endmodule

// File: rtl/lf_open_rows.sv
module lf_open_rows #(
   parameter int BANKS  = 4,
   parameter int ROW_W  = 12,
   parameter int BANK_W = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic              pre_i,
   input  logic [BANK_W-1:0] upd_bank_i,
   input  logic [ROW_W-1:0]  upd_row_i,
   input  logic [BANK_W-1:0] look_bank_i,
   input  logic [ROW_W-1:0]  look_row_i,
   output logic              hit_o
);
   logic [BANKS-1:0]       open_vec;
   logic [BANKS*ROW_W-1:0] row_flat;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic             open_q;
      logic [ROW_W-1:0] row_q;
      logic             sel;
      assign sel = (upd_bank_i == BANK_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
         end else if (act_i && sel) begin
            open_q <= 1'b1;
            row_q  <= upd_row_i;
         end else if (pre_i && sel) begin
            open_q <= 1'b0;
         end
      end
      assign open_vec[b]                   = open_q;
      assign row_flat[b*ROW_W +: ROW_W]    = row_q;
   end

   assign hit_o = open_vec[look_bank_i] &&
                  (row_flat[look_bank_i*ROW_W +: ROW_W] == look_row_i);

   // R5: a precharge leaves its bank closed in the following cycle
   a_r5_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |=> !open_vec[$past(upd_bank_i)]);
   // R5: an activate leaves its bank open on the activated row
   a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> (open_vec[$past(upd_bank_i)] &&
                 row_flat[$past(upd_bank_i)*ROW_W +: ROW_W] == $past(upd_row_i)));
endmodule

// File: rtl/lf_burst_capture.sv
module lf_burst_capture #(
   parameter int WORD_W = 64,
   parameter int WORDS  = 8,
   parameter int OFF_W  = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [OFF_W-1:0]  crit_i,
   input  logic [WORD_W-1:0] dq0_i,
   input  logic [WORD_W-1:0] dq1_i,
   output logic              done_o,
   output logic              valid_o,
   output logic              last_o,
   output logic [OFF_W-1:0]  idx0_o,
   output logic [OFF_W-1:0]  idx1_o,
   output logic [WORD_W-1:0] data0_o,
   output logic [WORD_W-1:0] data1_o
);
   localparam int PAIRS = WORDS / 2;
   localparam int PC_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;

   logic [PC_W-1:0]  pc_q;
   logic [OFF_W-1:0] base;

   assign done_o = cap_i && (pc_q == PC_W'(PAIRS - 1));
   assign base   = OFF_W'(crit_i + OFF_W'({pc_q, 1'b0}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= '0;
      else if (done_o) pc_q <= '0;
      else if (cap_i)  pc_q <= pc_q + PC_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         last_o  <= 1'b0;
         idx0_o  <= '0;
         idx1_o  <= '0;
         data0_o <= '0;
         data1_o <= '0;
      end else begin
         valid_o <= cap_i;
         last_o  <= done_o;
         if (cap_i) begin
            idx0_o  <= base;
            idx1_o  <= OFF_W'(base + OFF_W'(1));
            data0_o <= dq0_i;
            data1_o <= dq1_i;
         end
      end
   end

   // R6: consecutive pairs of one line advance the slot-0 index by two
   a_r6_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o) && !$past(last_o)) |->
         idx0_o == OFF_W'($past(idx0_o) + OFF_W'(2)));
   // R7: the final-pair flag never stands without valid data
   a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
endmodule

// File: rtl/dram_line_filler.sv
module dram_line_filler
   import lf_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int LINE_BYTES = 64,
   parameter int BANKS      = 4,
   parameter int ROW_W      = 12,
   parameter int COL_W      = 7,
   parameter int T_RP       = 13,
   parameter int T_RCD      = 14,
   parameter int T_CL       = 11,
   localparam int BANK_W    = $clog2(BANKS),
   localparam int ADDR_W    = ROW_W + BANK_W + COL_W,
   localparam int WORDS     = LINE_BYTES * 8 / WORD_W,
   localparam int OFF_W     = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic [1:0]        cmd_o,
   output logic [BANK_W-1:0] cmd_bank_o,
   output logic [ROW_W-1:0]  cmd_row_o,
   output logic [COL_W-1:0]  cmd_col_o,
   input  logic [WORD_W-1:0] dq0_i,
   input  logic [WORD_W-1:0] dq1_i,
   output logic              fill_valid_o,
   output logic              fill_last_o,
   output logic [OFF_W-1:0]  fill_idx0_o,
   output logic [OFF_W-1:0]  fill_idx1_o,
   output logic [WORD_W-1:0] fill_data0_o,
   output logic [WORD_W-1:0] fill_data1_o
);
   localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                         : ((T_RCD > T_CL) ? T_RCD : T_CL);
   localparam int CNT_W = $clog2(T_MAX + 1);

   // elaboration-time parameter checks
   if (!(LINE_BYTES == 32 || LINE_BYTES == 64)) begin : g_chk_line
      $error("LINE_BYTES must be 32 or 64");
   end
   if (WORD_W != 64) begin : g_chk_word
      $error("WORD_W must be 64");
   end
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_chk_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (COL_W < OFF_W) begin : g_chk_col
      $error("COL_W must cover a whole line");
   end
   if (T_RP < 2 || T_RCD < 2 || T_CL < 2) begin : g_chk_timing
      $error("every wait must be at least 2 cycles");
   end

   seq_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              accept, row_hit, burst_done;
   logic              t_load, t_expire, t_busy;
   logic [CNT_W-1:0]  t_val;
   logic [ROW_W-1:0]  look_row;
   logic [BANK_W-1:0] look_bank;
   dram_cmd_e         cmd_e;

   wire [ROW_W-1:0]  cur_row  = addr_q[ADDR_W-1 -: ROW_W];
   wire [BANK_W-1:0] cur_bank = addr_q[COL_W +: BANK_W];
   wire [COL_W-1:0]  cur_col  = addr_q[COL_W-1:0];

   assign req_ready_o = (state_q == ST_IDLE);
   assign accept      = req_valid_i && req_ready_o;
   assign look_row    = req_ready_o ? req_addr_i[ADDR_W-1 -: ROW_W] : cur_row;
   assign look_bank   = req_ready_o ? req_addr_i[COL_W +: BANK_W]   : cur_bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) addr_q <= req_addr_i;
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = row_hit ? ST_RD : ST_PRE;
         ST_PRE:   state_d = ST_WRP;
         ST_WRP:   if (t_expire) state_d = ST_ACT;
         ST_ACT:   state_d = ST_WRCD;
         ST_WRCD:  if (t_expire) state_d = ST_RD;
         ST_RD:    state_d = ST_WCL;
         ST_WCL:   if (t_expire) state_d = ST_BURST;
         ST_BURST: if (burst_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      cmd_e  = CMD_NOP;
      t_load = 1'b1;
      t_val  = '0;
      unique case (state_q)
         ST_PRE: begin cmd_e = CMD_PRE; t_val = CNT_W'(T_RP - 1);  end
         ST_ACT: begin cmd_e = CMD_ACT; t_val = CNT_W'(T_RCD - 1); end
         ST_RD:  begin cmd_e = CMD_RD;  t_val = CNT_W'(T_CL - 1);  end
         default: t_load = 1'b0;
      endcase
   end

   assign cmd_o      = cmd_e;
   assign cmd_bank_o = cur_bank;
   assign cmd_row_o  = cur_row;
   assign cmd_col_o  = cur_col;

   lf_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (t_load),
      .val_i    (t_val),
      .expire_o (t_expire),
      .busy_o   (t_busy)
   );

   lf_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (state_q == ST_ACT),
      .pre_i       (state_q == ST_PRE),
      .upd_bank_i  (cur_bank),
      .upd_row_i   (cur_row),
      .look_bank_i (look_bank),
      .look_row_i  (look_row),
      .hit_o       (row_hit)
   );

   lf_burst_capture #(.WORD_W(WORD_W), .WORDS(WORDS), .OFF_W(OFF_W)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (state_q == ST_BURST),
      .crit_i  (cur_col[OFF_W-1:0]),
      .dq0_i   (dq0_i),
      .dq1_i   (dq1_i),
      .done_o  (burst_done),
      .valid_o (fill_valid_o),
      .last_o  (fill_last_o),
      .idx0_o  (fill_idx0_o),
      .idx1_o  (fill_idx1_o),
      .data0_o (fill_data0_o),
      .data1_o (fill_data1_o)
   );

   // R8: no new request is taken while a line is still being delivered
   a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid_o && !fill_last_o) |-> !req_ready_o);
   // R4: a read is only issued to a bank whose open row matches the request
   a_r4_rd_open_row: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_RD) |-> row_hit);
   // R2: the bus stays quiet while a wait is counting
   a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
      t_busy |-> (cmd_o == CMD_NOP));
   // R9: a request seen while busy does not change the latched address
   a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready_o |=> (req_ready_o || $stable(addr_q)));
endmodule

// File: tb/dram_line_filler_bench.sv
module dram_line_filler_bench;
   localparam int WORD_W = 64;
   localparam int LINE_BYTES = 64;
   localparam int BANKS = 4;
   localparam int ROW_W = 12;
   localparam int COL_W = 7;
   localparam int T_RP = 13;
   localparam int T_RCD = 14;
   localparam int T_CL = 11;
   localparam int BANK_W = 2;
   localparam int ADDR_W = ROW_W + BANK_W + COL_W;
   localparam int WORDS = 8;
   localparam int OFF_W = 3;
   localparam int PAIRS = WORDS / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0] cmd;
   logic [BANK_W-1:0] cmd_bank;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;
   logic [WORD_W-1:0] dq0 = '0, dq1 = '0;
   logic fill_valid, fill_last;
   logic [OFF_W-1:0] fill_idx0, fill_idx1;
   logic [WORD_W-1:0] fill_data0, fill_data1;

   always #2 clk = ~clk;

   dram_line_filler #(
      .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .BANKS(BANKS), .ROW_W(ROW_W),
      .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)
   ) u_dram_line_filler (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_addr_i(req_addr), .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row),
      .cmd_col_o(cmd_col), .dq0_i(dq0), .dq1_i(dq1), .fill_valid_o(fill_valid),
      .fill_last_o(fill_last), .fill_idx0_o(fill_idx0), .fill_idx1_o(fill_idx1),
      .fill_data0_o(fill_data0), .fill_data1_o(fill_data1)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   // per-request logs
   int nreq = 0, fill_req = 0;
   int acc[16], pre_n[16], act_n[16], rd_n[16];
   int pre_cyc[16], act_cyc[16], act_row[16], act_bank[16], rd_cyc[16], rd_col[16];
   int npair[16], first_fill[16], last_cyc[16], last_pos[16], lastcnt[16], viol[16];
   int rdy_last[16];
   int fidx0[16][8], fidx1[16][8];
   logic [63:0] fdat0[16][8], fdat1[16][8];

   // responder state
   int rsp_row[4];
   bit rsp_on = 0;
   int rsp_rd = 0, rsp_bank = 0, rsp_col = 0;

   function automatic logic [63:0] mk(int row, int bank, int col);
      return 64'hA500_0000_0000_0000 | (64'(row) << 32) | (64'(bank) << 20) | 64'(col);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor and DRAM responder, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         int cur;
         cur = nreq - 1;
         if (fill_valid) begin
            int f, np;
            f = fill_req;
            np = npair[f];
            if (np < 8) begin
               fidx0[f][np] = int'(fill_idx0);
               fidx1[f][np] = int'(fill_idx1);
               fdat0[f][np] = fill_data0;
               fdat1[f][np] = fill_data1;
            end
            if (np == 0) first_fill[f] = cyc;
            npair[f] = np + 1;
            if (fill_last) begin
               lastcnt[f]++;
               last_pos[f] = np;
               last_cyc[f] = cyc;
               rdy_last[f] = int'(req_ready);
               fill_req++;
            end else if (req_ready) viol[f]++;
         end else if (nreq > fill_req && req_ready) begin
            viol[fill_req]++;
         end
         if (cur >= 0) begin
            case (cmd)
               2'd1: begin pre_n[cur]++; pre_cyc[cur] = cyc; end
               2'd2: begin
                  act_n[cur]++; act_cyc[cur] = cyc;
                  act_row[cur] = int'(cmd_row); act_bank[cur] = int'(cmd_bank);
                  rsp_row[int'(cmd_bank)] = int'(cmd_row);
               end
               2'd3: begin
                  rd_n[cur]++; rd_cyc[cur] = cyc; rd_col[cur] = int'(cmd_col);
                  rsp_on = 1; rsp_rd = cyc; rsp_bank = int'(cmd_bank); rsp_col = int'(cmd_col);
               end
               default: ;
            endcase
         end
         if (rsp_on && cyc >= rsp_rd + T_CL && cyc < rsp_rd + T_CL + PAIRS) begin
            int j, base, crit;
            j = cyc - rsp_rd - T_CL;
            base = rsp_col & ~(WORDS - 1);
            crit = rsp_col % WORDS;
            dq0 = mk(rsp_row[rsp_bank], rsp_bank, base + ((crit + 2*j) % WORDS));
            dq1 = mk(rsp_row[rsp_bank], rsp_bank, base + ((crit + 2*j + 1) % WORDS));
         end else begin
            dq0 = 64'hDEAD_0000_0000_0000;
            dq1 = 64'hDEAD_0000_0000_0001;
         end
         if (req_valid && req_ready) begin
            acc[nreq] = cyc + 1;
            nreq++;
         end
      end
   end

   function automatic logic [ADDR_W-1:0] pack(int row, int bank, int col);
      return {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
   endfunction

   task automatic present(input int row, input int bank, input int col);
      @(posedge clk); #1;
      req_valid = 1'b1;
      req_addr = pack(row, bank, col);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic wait_line(input int n);
      while (fill_req <= n) @(negedge clk);
   endtask

   task automatic check_line(input int n, input int row, input int bank, input int col,
                             input bit hit);
      int base, crit;
      base = col & ~(WORDS - 1);
      crit = col % WORDS;
      if (hit) begin
         chk(pre_n[n] == 0, "R4 no precharge on open row", pre_n[n], 0);
         chk(act_n[n] == 0, "R4 no activate on open row", act_n[n], 0);
         chk(rd_cyc[n] == acc[n], "R4 read right after accept", rd_cyc[n], acc[n]);
      end else begin
         chk(pre_n[n] == 1, "R2 one precharge", pre_n[n], 1);
         chk(pre_cyc[n] == acc[n], "R2 precharge cycle", pre_cyc[n], acc[n]);
         chk(act_cyc[n] == acc[n] + T_RP, "R2 activate after T_RP", act_cyc[n], acc[n] + T_RP);
         chk(act_row[n] == row && act_bank[n] == bank, "R2 activate row/bank",
             act_row[n] * 16 + act_bank[n], row * 16 + bank);
         chk(rd_cyc[n] == acc[n] + T_RP + T_RCD, "R2 read after T_RCD",
             rd_cyc[n], acc[n] + T_RP + T_RCD);
      end
      chk(rd_n[n] == 1, "R2 one read", rd_n[n], 1);
      chk(rd_col[n] == col, "R6 read column", rd_col[n], col);
      chk(first_fill[n] == rd_cyc[n] + T_CL + 1, "R3 first pair latency",
          first_fill[n], rd_cyc[n] + T_CL + 1);
      chk(npair[n] == PAIRS, "R7 pair count", npair[n], PAIRS);
      chk(lastcnt[n] == 1 && last_pos[n] == PAIRS - 1, "R7 last flag position",
          last_pos[n], PAIRS - 1);
      chk(last_cyc[n] == first_fill[n] + PAIRS - 1, "R7 consecutive pairs",
          last_cyc[n], first_fill[n] + PAIRS - 1);
      for (int j = 0; j < PAIRS; j++) begin
         int e0, e1;
         e0 = (crit + 2*j) % WORDS;
         e1 = (crit + 2*j + 1) % WORDS;
         chk(fidx0[n][j] == e0, "R6 slot0 index", fidx0[n][j], e0);
         chk(fidx1[n][j] == e1, "R6 slot1 index", fidx1[n][j], e1);
         chk(fdat0[n][j] == mk(row, bank, base + e0), "R6 slot0 data",
             fdat0[n][j], mk(row, bank, base + e0));
         chk(fdat1[n][j] == mk(row, bank, base + e1), "R6 slot1 data",
             fdat1[n][j], mk(row, bank, base + e1));
      end
      chk(viol[n] == 0, "R8 ready low while busy", viol[n], 0);
      chk(rdy_last[n] == 1, "R8 ready with last pair", rdy_last[n], 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(cmd == 2'd0, "R1 command idle", cmd, 0);
      chk(fill_valid == 1'b0, "R1 no fill", fill_valid, 0);
   endtask

   task automatic t_single(input int row, input int bank, input int col, input bit hit);
      int n;
      n = nreq;
      present(row, bank, col);
      req_valid = 1'b0;
      wait_line(n);
      check_line(n, row, bank, col, hit);
   endtask

   // R9: second request held through the first line, taken on the last-pair cycle
   task automatic t_back_to_back;
      int n;
      n = nreq;
      present(9, 2, 20);
      req_addr = pack(3, 1, 5);
      while (nreq < n + 2) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      wait_line(n + 1);
      check_line(n, 9, 2, 20, 1'b1);
      chk(acc[n + 1] == last_cyc[n] + 1, "R9 held request taken after last pair",
          acc[n + 1], last_cyc[n] + 1);
      check_line(n + 1, 3, 1, 5, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single(5, 0, 3, 1'b0);   // R5 closed bank after reset
      t_single(5, 0, 9, 1'b1);   // R4 hit
      t_single(6, 0, 0, 1'b0);   // R2 row conflict
      t_single(9, 2, 15, 1'b0);  // R5 other bank, R6 wrap from index 7
      t_single(6, 0, 14, 1'b1);  // R5 bank 0 kept its row
      t_back_to_back();
      repeat (4) @(negedge clk);
      chk(nreq == 7, "R9 requests taken once each", nreq, 7);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule